// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave with Write-Protect Abort

This block is the target side of a two-wire serial bus that behaves like a 256-byte, byte-wide non-volatile memory. It works from a fast system clock and treats the bus clock and data lines as asynchronous inputs. Each line passes through a two-flop synchronizer, and every bus event is taken from the synchronized samples. A bus transaction opens with a start condition. A 7-bit device address and a direction bit follow. A write then carries a word address and one or more data bytes, and the slave acknowledges every byte it accepts. Data bytes are collected in an 8-byte page buffer. The buffered bytes reach the array only in a timed internal write cycle, and that cycle begins when the master sends a stop.

Reads return array data on the bus, changing the data line after falling edges of the bus clock. A random read is a dummy write that sets the word address, followed by a repeated start in the read direction. A write-protect input is watched from the clock rise that captures the last bit of the first data byte until the write cycle finishes. If it rises before the stop, the pending write is dropped. If it rises during the write cycle, the cycle is cut short and the byte under access is left corrupted.

The data line is modelled as a wired-AND bus: the slave only ever pulls it low, and the surrounding logic resolves the bus level.

Top module: `twowire_eeprom`

## Requirements
- R1: After reset the slave does not pull SDA low, and every array location reads 0xFF.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Bits are taken on SCL rising edges, most significant bit first.
- R3: The first byte after a start holds a 7-bit device address (default 0x50) in bits 7..1 and the direction in bit 0 (0 = write, 1 = read). A byte with any other device address is not acknowledged, and the slave stays silent until the next start.
- R4: The slave acknowledges, by holding SDA low through the ninth clock, each matching device address, each word address and each data byte of a write.
- R5: Read data changes after SCL falling edges, most significant bit first. A random read returns the byte at the word address just written. Further bytes come from successive addresses while the master acknowledges, and a master not-acknowledge ends the read.
- R6: Written bytes reach the array only after a stop, at the end of an internal write cycle lasting WR_CYCLES clocks. While that cycle runs, the slave acknowledges no device address.
- R7: A write of more than one byte fills an 8-byte page. The low 3 address bits advance and wrap within the page, so later bytes overwrite earlier ones, and bytes outside the page are not touched.
- R8: If WP is high at any time after the SCL rise that captures the last bit of the first data byte and before the stop, the write is cancelled. The array is unchanged and no write cycle starts, so a poll right after the stop is acknowledged.
- R9: If WP goes high during the write cycle, the cycle ends at once and the slave answers polls again. The other bytes of the page keep their old contents. The byte at the starting address is undefined.
- R10: WP high only while the device address and word address are being sent does not block the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock level (asynchronous) |
| sdaIn | input | 1 | Resolved bus data level (asynchronous) |
| wpIn | input | 1 | Write-protect; high blocks or aborts a write |
| sdaDriveLow | output | 1 | 1 = slave pulls SDA low |

## Verification
The hardest states to reach from the ports are the two write-protect windows. In one, WP rises after the first data byte has been taken but before the stop. In the other, WP rises in the middle of an internal write cycle. The bit-banged master raises WP right after a data byte's acknowledge to test cancellation, and a poll straight after the stop must then be acknowledged. To test the forced end, it raises WP a few clocks after the stop and polls well inside the write-cycle length, then reads back the untouched bytes of the same page. Page wrap is reached by writing ten bytes from the middle of a page and reading the whole page back in sequence.

// File: rtl/twe_pkg.sv
`timescale 1ns/1ps
package twe_pkg;

  // Strobes from control to datapath, one clock wide each.
  typedef struct packed {
    logic shiftIn;   // take synchronized SDA into the receive shifter
    logic loadAddr;  // latch word address, empty the page buffer
    logic bufWrite;  // store received byte into the page buffer
    logic loadTx;    // fetch array byte into the transmit shifter
    logic shiftOut;  // present next transmit bit
    logic commit;    // copy buffered bytes into the array
    logic corrupt;   // forced end: damage the byte under access
  } strobe_t;

  // Synchronized bus events from datapath to control.
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic start;
    logic stop;
    logic sdaBit;
    logic wpHigh;
  } event_t;

endpackage

// File: rtl/twe_data.sv
`timescale 1ns/1ps
module twe_data
  import twe_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int PAGE  = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       wpIn,
  input  strobe_t    st,
  output event_t     ev,
  output logic [7:0] rxByte,
  output logic       txBit,
  output logic       bufAny
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = $clog2(PAGE);

  logic [2:0]    sclPipe, sdaPipe;
  logic [1:0]    wpPipe;
  logic [7:0]    mem [DEPTH];
  logic [7:0]    pageBuf [PAGE];
  logic [PAGE-1:0] bufValid;
  logic [AW-1:0] addrReg;
  logic [PW-1:0] ptr;
  logic [7:0]    rxShift, txShift;

  // Two-flop synchronizers plus one history stage for edge detection.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      wpPipe  <= '0;
    end else begin
      sclPipe <= {sclPipe[1:0], sclIn};
      sdaPipe <= {sdaPipe[1:0], sdaIn};
      wpPipe  <= {wpPipe[0], wpIn};
    end
  end

  always_comb begin
    ev.sclRise = sclPipe[1] & ~sclPipe[2];
    ev.sclFall = ~sclPipe[1] & sclPipe[2];
    ev.start   = sclPipe[1] & sclPipe[2] & sdaPipe[2] & ~sdaPipe[1];
    ev.stop    = sclPipe[1] & sclPipe[2] & ~sdaPipe[2] & sdaPipe[1];
    ev.sdaBit  = sdaPipe[1];
    ev.wpHigh  = wpPipe[1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      for (int i = 0; i < PAGE; i++) pageBuf[i] <= '0;
      bufValid <= '0;
      addrReg  <= '0;
      ptr      <= '0;
      rxShift  <= '0;
      txShift  <= '1;
    end else begin
      if (st.shiftIn) rxShift <= {rxShift[6:0], ev.sdaBit};
      if (st.loadAddr) begin
        addrReg  <= rxShift[AW-1:0];
        ptr      <= rxShift[PW-1:0];
        bufValid <= '0;
      end
      if (st.bufWrite) begin
        pageBuf[ptr]  <= rxShift;
        bufValid[ptr] <= 1'b1;
        ptr           <= ptr + 1'b1;
      end
      if (st.loadTx) begin
        txShift <= mem[addrReg];
        addrReg <= addrReg + 1'b1;
      end else if (st.shiftOut) begin
        txShift <= {txShift[6:0], 1'b1};
      end
      if (st.commit) begin
        for (int i = 0; i < PAGE; i++)
          if (bufValid[i]) mem[{addrReg[AW-1:PW], PW'(i)}] <= pageBuf[i];
        bufValid <= '0;
      end
      if (st.corrupt) begin
        mem[addrReg] <= ~pageBuf[addrReg[PW-1:0]];
        bufValid     <= '0;
      end
    end
  end

  assign rxByte = rxShift;
  assign txBit  = txShift[7];
  assign bufAny = |bufValid;

  // R6: a finished write cycle leaves nothing pending in the page buffer.
  a_r6_commit_empties: assert property (@(posedge clk) disable iff (!rstN)
    (st.commit || st.corrupt) |=> !bufAny);

  // R2: start and stop can never be reported in the same cycle.
  a_r2_start_stop_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(ev.start && ev.stop));

endmodule

// File: rtl/twe_ctrl.sv
`timescale 1ns/1ps
module twe_ctrl
  import twe_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h50,
  parameter int         WR_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  event_t     ev,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  input  logic       bufAny,
  output strobe_t    st,
  output logic       sdaDriveLow
);
  localparam int CW = $clog2(WR_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK, S_WCYC} state_t;
  typedef enum logic [1:0] {K_DEV, K_WORD, K_DATA} kind_t;

  state_t state, stateN;
  kind_t  kind, kindN;
  logic [2:0]    bitCnt, bitCntN;
  logic          byteDone, byteDoneN, readMode, readModeN;
  logic          armed, armedN, cancel, cancelN, mAck, mAckN;
  logic [CW-1:0] wcCnt, wcCntN;

  always_comb begin
    st        = '0;
    stateN    = state;
    kindN     = kind;
    bitCntN   = bitCnt;
    byteDoneN = byteDone;
    readModeN = readMode;
    armedN    = armed;
    cancelN   = cancel;
    mAckN     = mAck;
    wcCntN    = wcCnt;
    if (state == S_WCYC) begin
      wcCntN = wcCnt + 1'b1;
      if (ev.wpHigh) begin
        st.corrupt = 1'b1;
        stateN     = S_IDLE;
      end else if (wcCnt == CW'(WR_CYCLES - 1)) begin
        st.commit = 1'b1;
        stateN    = S_IDLE;
      end
    end else if (ev.start) begin
      stateN    = S_RX;
      kindN     = K_DEV;
      bitCntN   = '0;
      byteDoneN = 1'b0;
      readModeN = 1'b0;
      armedN    = 1'b0;
      cancelN   = 1'b0;
    end else if (ev.stop) begin
      stateN  = (kind == K_DATA && armed && !cancel && bufAny) ? S_WCYC : S_IDLE;
      armedN  = 1'b0;
      wcCntN  = '0;
    end else begin
      if (armed && ev.wpHigh) cancelN = 1'b1;
      case (state)
        S_RX: begin
          if (ev.sclRise) begin
            st.shiftIn = 1'b1;
            bitCntN    = bitCnt + 3'd1;
            if (bitCnt == 3'd7) begin
              byteDoneN = 1'b1;
              if (kind == K_DATA) armedN = 1'b1;
            end
          end else if (ev.sclFall && byteDone) begin
            byteDoneN = 1'b0;
            bitCntN   = '0;
            case (kind)
              K_DEV: begin
                if (rxByte[7:1] == DEV_ADDR) begin
                  stateN    = S_ACK;
                  readModeN = rxByte[0];
                  kindN     = K_WORD;
                end else begin
                  stateN = S_IDLE;
                end
              end
              K_WORD: begin
                st.loadAddr = 1'b1;
                stateN      = S_ACK;
                kindN       = K_DATA;
              end
              default: begin
                st.bufWrite = 1'b1;
                stateN      = S_ACK;
              end
            endcase
          end
        end
        S_ACK: begin
          if (ev.sclFall) begin
            if (readMode) begin
              st.loadTx = 1'b1;
              stateN    = S_TX;
            end else begin
              stateN = S_RX;
            end
          end
        end
        S_TX: begin
          if (ev.sclRise) begin
            bitCntN = bitCnt + 3'd1;
            if (bitCnt == 3'd7) byteDoneN = 1'b1;
          end else if (ev.sclFall) begin
            if (byteDone) begin
              byteDoneN = 1'b0;
              bitCntN   = '0;
              stateN    = S_MACK;
            end else begin
              st.shiftOut = 1'b1;
            end
          end
        end
        S_MACK: begin
          if (ev.sclRise) begin
            mAckN = ~ev.sdaBit;
          end else if (ev.sclFall) begin
            if (mAck) begin
              st.loadTx = 1'b1;
              stateN    = S_TX;
            end else begin
              stateN = S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      kind     <= K_DEV;
      bitCnt   <= '0;
      byteDone <= 1'b0;
      readMode <= 1'b0;
      armed    <= 1'b0;
      cancel   <= 1'b0;
      mAck     <= 1'b0;
      wcCnt    <= '0;
    end else begin
      state    <= stateN;
      kind     <= kindN;
      bitCnt   <= bitCntN;
      byteDone <= byteDoneN;
      readMode <= readModeN;
      armed    <= armedN;
      cancel   <= cancelN;
      mAck     <= mAckN;
      wcCnt    <= wcCntN;
    end
  end

  assign sdaDriveLow = (state == S_ACK) || (state == S_TX && !txBit);

  // R2: bits enter the shifter only on a synchronized SCL rise.
  a_r2_shift_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    st.shiftIn |-> ev.sclRise);

  // R4: an acknowledge phase is only entered after a complete byte.
  a_r4_ack_after_byte: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ACK && $past(state) != S_ACK) |-> $past(byteDone));

  // R6: a running write cycle leaves only to idle, never to a bus phase.
  a_r6_busy_exits_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WCYC) |=> (state == S_WCYC || state == S_IDLE));

  // R6: the write-cycle counter stays inside its length.
  a_r6_cycle_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WCYC) |-> (wcCnt < CW'(WR_CYCLES)));

  // R8: a cancelled write never starts a write cycle at the stop.
  a_r8_cancel_no_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (cancel && ev.stop && state != S_WCYC) |=> state != S_WCYC);

  // R9: write-protect during the cycle ends it on the next clock.
  a_r9_wp_force_end: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WCYC && ev.wpHigh) |=> state == S_IDLE);

endmodule

// File: rtl/twowire_eeprom.sv
`timescale 1ns/1ps
module twowire_eeprom
  import twe_pkg::*;
#(
  parameter int         DEPTH     = 256,
  parameter int         PAGE      = 8,
  parameter logic [6:0] DEV_ADDR  = 7'h50,
  parameter int         WR_CYCLES = 1000
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic wpIn,
  output logic sdaDriveLow
);
  strobe_t    st;
  event_t     ev;
  logic [7:0] rxByte;
  logic       txBit;
  logic       bufAny;

  twe_data #(.DEPTH(DEPTH), .PAGE(PAGE)) u_data (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .wpIn(wpIn),
    .st(st), .ev(ev), .rxByte(rxByte), .txBit(txBit), .bufAny(bufAny)
  );

  twe_ctrl #(.DEV_ADDR(DEV_ADDR), .WR_CYCLES(WR_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .ev(ev), .rxByte(rxByte), .txBit(txBit),
    .bufAny(bufAny), .st(st), .sdaDriveLow(sdaDriveLow)
  );

endmodule

// File: tb/twowire_eeprom_bench.sv
`timescale 1ns/1ps
module twowire_eeprom_bench;
  localparam int QC = 8;        // clocks per quarter bit
  localparam int WR = 1000;     // matches design default write-cycle length
  localparam int NV = 6;
  // Each vector: {word address, data}
  localparam logic [15:0] VEC [NV] = '{16'h003C, 16'h01A5, 16'h7F00,
                                       16'h8055, 16'hC3C3, 16'hFE81};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1, wpIn = 1'b0;
  logic sdaDriveLow;
  logic sdaBus;
  int   checks = 0, errors = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;
  assign sdaBus = mSda & ~sdaDriveLow;

  twowire_eeprom u_twowire_eeprom (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaBus), .wpIn(wpIn),
    .sdaDriveLow(sdaDriveLow)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic qwait(); repeat (QC) @(negedge clk); endtask
  task automatic busStart(); mSda = 1; qwait(); mScl = 1; qwait(); mSda = 0; qwait(); mScl = 0; qwait(); endtask
  task automatic busStop(); mSda = 0; qwait(); mScl = 1; qwait(); mSda = 1; qwait(); endtask
  task automatic sendBit(input logic b); mSda = b; qwait(); mScl = 1; qwait(); qwait(); mScl = 0; qwait(); endtask
  task automatic recvBit(output logic b); mSda = 1; qwait(); mScl = 1; qwait(); b = sdaBus; qwait(); mScl = 0; qwait(); endtask

  task automatic sendByte(input logic [7:0] d, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    recvBit(b);
    acked = ~b;
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin recvBit(b); d[i] = b; end
    sendBit(~ackIt);
  endtask

  task automatic writeOne(input logic [7:0] a, input logic [7:0] d, output logic allAck);
    logic k1, k2, k3;
    busStart(); sendByte(8'hA0, k1); sendByte(a, k2); sendByte(d, k3); busStop();
    allAck = k1 & k2 & k3;
  endtask

  task automatic readOne(input logic [7:0] a, output logic [7:0] d, output logic allAck);
    logic k1, k2, k3;
    busStart(); sendByte(8'hA0, k1); sendByte(a, k2);
    busStart(); sendByte(8'hA1, k3); recvByte(1'b0, d); busStop();
    allAck = k1 & k2 & k3;
  endtask

  task automatic poll(output logic acked);
    busStart(); sendByte(8'hA0, acked); busStop();
  endtask

  task automatic waitCycle(); repeat (WR + 100) @(negedge clk); endtask

  initial begin
    logic ok, k;
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset state
    check("R1 sda released", int'(sdaDriveLow), 0);
    readOne(8'h05, d, ok);
    check("R1 read acks", int'(ok), 1);
    check("R1 erased value", int'(d), 8'hFF);

    // Vector table: R2 R4 R5 R6 single-byte write and random read
    for (int i = 0; i < NV; i++) begin
      writeOne(VEC[i][15:8], VEC[i][7:0], ok);
      check("R4 write acks", int'(ok), 1);
      waitCycle();
      readOne(VEC[i][15:8], d, ok);
      check("R5 read acks", int'(ok), 1);
      check("R2 R5 readback", int'(d), int'(VEC[i][7:0]));
    end

    // R3: foreign device address gets no acknowledge
    busStart(); sendByte(8'hA4, k); busStop();
    check("R3 foreign write nack", int'(k), 0);
    busStart(); sendByte(8'hA3, k); busStop();
    check("R3 foreign read nack", int'(k), 0);

    // R6: busy during write cycle
    writeOne(8'h40, 8'h12, ok);
    poll(k);
    check("R6 busy nack", int'(k), 0);
    waitCycle();
    poll(k);
    check("R6 ready ack", int'(k), 1);
    readOne(8'h40, d, ok);
    check("R6 committed", int'(d), 8'h12);

    // R7: page write with wrap, then sequential read
    busStart(); sendByte(8'hA0, k); sendByte(8'h16, k);
    for (int i = 0; i < 10; i++) begin
      sendByte(8'h60 + 8'(i), k);
      check("R7 data ack", int'(k), 1);
    end
    busStop();
    waitCycle();
    busStart(); sendByte(8'hA0, k); sendByte(8'h10, k);
    busStart(); sendByte(8'hA1, k);
    for (int j = 0; j < 9; j++) begin
      recvByte(j < 8, d);
      if (j < 8) check("R7 R5 page byte", int'(d), 8'h62 + j);
      else       check("R7 outside page", int'(d), 8'hFF);
    end
    busStop();

    // R8: WP during data phase cancels the write
    busStart(); sendByte(8'hA0, k); sendByte(8'h20, k); sendByte(8'h11, k);
    wpIn = 1'b1; qwait();
    busStop();
    repeat (10) @(negedge clk);
    wpIn = 1'b0;
    poll(k);
    check("R8 no write cycle", int'(k), 1);
    readOne(8'h20, d, ok);
    check("R8 memory unchanged", int'(d), 8'hFF);

    // R9: WP during write cycle forces it to end
    busStart(); sendByte(8'hA0, k); sendByte(8'h48, k);
    for (int i = 0; i < 4; i++) sendByte(8'h90 + 8'(i), k);
    busStop();
    repeat (20) @(negedge clk);
    wpIn = 1'b1;
    repeat (10) @(negedge clk);
    poll(k);
    check("R9 cycle ended", int'(k), 1);
    wpIn = 1'b0;
    for (int j = 1; j < 4; j++) begin
      readOne(8'h48 + 8'(j), d, ok);
      check("R9 page untouched", int'(d), 8'hFF);
    end

    // R10: WP high only during addressing does not block the write
    wpIn = 1'b1;
    busStart(); sendByte(8'hA0, k); sendByte(8'h30, k);
    wpIn = 1'b0;
    sendByte(8'h5A, k); busStop();
    poll(k);
    check("R10 cycle running", int'(k), 0);
    waitCycle();
    readOne(8'h30, d, ok);
    check("R10 written", int'(d), 8'h5A);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule